// File: doc/BRIEF.md
# I2C Write Master with Command Queue

This block is an I2C bus master that only writes. Software queues 10-bit command words into a small transmit queue. The engine pulls the words one at a time and turns them into START conditions, bytes and STOP conditions. It drives the two open-drain lines through active-high pull-down enables, so `scl_oe = 1` means SCL is held low. After each byte it releases SDA for a ninth clock and reads the acknowledge. If the target answers with a NACK, the engine ends the transfer with a STOP and throws away whatever is still queued.

Software reaches the block through a word-wide register port. Address 0 is control: bit 0 enables the engine and bit 1 holds the queue empty. Address 1 is status (read only). Address 2 pushes a command word. Address 3 holds the divider. Reads are combinational on `reg_addr`, and a write takes effect on the clock edge where `reg_wr` is high.

Internally the queue talks to the engine over a valid/ready pair. The engine asserts ready only while it sits between bytes with SCL low, or while the bus is idle. Until then a word stays at the head of the queue, and back-pressure reaches software as the full flag. One bit time is four quarter periods. Each quarter lasts DIV+1 system clocks, where DIV is the divider register and must be at least 2.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, status reads 0x00C0 and both SCL and SDA are released. The status bits are: 7 queue empty, 6 receive side empty (always 1), 5 queue full, 2 bus busy, 1 NACK seen, 0 overflow.
- R2: In a command word, bits 7:0 are the byte, bit 8 requests a START before it and bit 9 requests a STOP after it. A word taken while the bus is idle always begins with a START, whether or not bit 8 is set.
- R3: Bytes are shifted MSB first. SDA changes only while SCL is low, with two exceptions: START (SDA falls while SCL is high) and STOP (SDA rises while SCL is high).
- R4: After the eighth bit the master releases SDA and drives a ninth SCL pulse. SDA low on that pulse is an ACK and the transfer goes on.
- R5: SDA high on the ninth pulse is a NACK. The master then issues a STOP, empties the queue and sets status bit 1. No further bus activity follows. Any control write clears bit 1.
- R6: A word with the STOP flag is followed, after its acknowledge, by a STOP. The bus then goes idle and status bit 2 clears.
- R7: A word with the START flag taken in the middle of a transfer produces a repeated START before its byte.
- R8: If the queue runs empty in the middle of a transfer and no STOP was requested, SCL is held low and busy stays set. The transfer resumes when the next word is written.
- R9: A write to a full queue is dropped and sets the sticky overflow bit 0. Status bit 5 shows the queue is full. Any control write clears bit 0.
- R10: While control bit 0 is 0, no word is taken from the queue. While control bit 1 is 1, the queue is held empty and words written to it are dropped. Writing 0x1 enables the engine and releases the hold.
- R11: SCL stays high for 2*(DIV+1) system clocks in each data and acknowledge bit. DIV resets to the DEFAULT_DIV parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| sda_in | input | 1 | Sensed level of the SDA line |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |

## Verification
The assertions take four things for granted about the inputs. The divider is at least 2, so the two-flop synchronizer on SDA settles before the acknowledge is sampled. The SDA input follows the wired-AND of the master and one target. SCL is never held low by anything other than the master. No other master starts a transfer. The bench models a single target that pulls SDA only from the SCL falling edge after the eighth bit until the falling edge after the ninth. It keeps the divider at 3 or above and never drives SCL, so the stimulus stays inside those assumptions.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int CMD_W = 10;

  typedef struct packed {
    logic       stop;
    logic       start;
    logic [7:0] data;
  } cmd_word_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_BIT,
    ST_ACK,
    ST_STOP,
    ST_WAIT
  } eng_state_e;

  localparam logic [1:0] RA_CTRL   = 2'd0;
  localparam logic [1:0] RA_STATUS = 2'd1;
  localparam logic [1:0] RA_PUSH   = 2'd2;
  localparam logic [1:0] RA_DIV    = 2'd3;

endpackage

// File: rtl/i2cm_cmd_fifo.sv
module i2cm_cmd_fifo
  import i2cm_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clr,
  input  logic      in_valid,
  output logic      in_ready,
  input  cmd_word_t in_data,
  output logic      out_valid,
  input  logic      out_ready,
  output cmd_word_t out_data
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  cmd_word_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  assign in_ready  = (count != FULL_CNT);
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign do_wr     = in_valid && in_ready && !clr;
  assign do_rd     = out_valid && out_ready && !clr;

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !out_valid); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT); // R9

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!out_valid && !in_valid) |-> !out_valid || $past(clr)); // R8

endmodule

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);

  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div) && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick || (div == '0)); // R11

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      cmd_valid,
  output logic      cmd_ready,
  input  cmd_word_t cmd_data,
  input  logic      tick,
  output logic      restart,
  input  logic      sda_in,
  output logic      scl_oe,
  output logic      sda_oe,
  output logic      busy,
  output logic      nack_evt
);

  eng_state_e st;
  logic [1:0] q;
  logic [2:0] bidx;
  logic [7:0] sh;
  logic       stop_pend;
  logic       ack_hi;
  logic       fetch;
  logic       bus_phase;

  assign cmd_ready = (st == ST_IDLE || st == ST_WAIT) && enable;
  assign fetch     = cmd_ready && cmd_valid;
  assign restart   = fetch;
  assign busy      = (st != ST_IDLE);
  assign bus_phase = (st == ST_START) || (st == ST_BIT) ||
                     (st == ST_ACK)   || (st == ST_STOP);
  assign nack_evt  = tick && (st == ST_ACK) && (q == 2'd3) && ack_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      q         <= '0;
      bidx      <= '0;
      sh        <= '0;
      stop_pend <= 1'b0;
      ack_hi    <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (fetch) begin
      sh        <= cmd_data.data;
      stop_pend <= cmd_data.stop;
      q         <= '0;
      bidx      <= 3'd7;
      st        <= (st == ST_IDLE || cmd_data.start) ? ST_START : ST_BIT;
    end else if (tick && bus_phase) begin
      q <= q + 1'b1;
      case (st)
        ST_START: begin
          case (q)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: begin
              scl_oe <= 1'b1;
              st     <= ST_BIT;
            end
          endcase
        end
        ST_BIT: begin
          case (q)
            2'd0: sda_oe <= ~sh[7];
            2'd1: scl_oe <= 1'b0;
            2'd2: ;
            default: begin
              scl_oe <= 1'b1;
              sh     <= {sh[6:0], 1'b0};
              if (bidx == 3'd0) st <= ST_ACK;
              else              bidx <= bidx - 1'b1;
            end
          endcase
        end
        ST_ACK: begin
          case (q)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: ack_hi <= sda_in;
            default: begin
              scl_oe <= 1'b1;
              st     <= (ack_hi || stop_pend) ? ST_STOP : ST_WAIT;
            end
          endcase
        end
        ST_STOP: begin
          case (q)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: st <= ST_IDLE;
          endcase
        end
        default: st <= st;
      endcase
    end
  end

  AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (st == ST_START || st == ST_STOP)); // R3

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> (!scl_oe && !sda_oe)); // R1

  AST_NACK_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    nack_evt |=> (st == ST_STOP)); // R5

  AST_WAIT_HOLDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_WAIT) |-> scl_oe); // R8

  AST_ACK_RELEASES_SDA: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_ACK && q >= 2'd1) |-> !sda_oe); // R4

endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
  import i2cm_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int DIV_W       = 16,
  parameter int DEFAULT_DIV = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        sda_in,
  output logic        scl_oe,
  output logic        sda_oe
);

  localparam logic [DIV_W-1:0] DIV_RST = DIV_W'(DEFAULT_DIV);

  logic             en_q, hold_q, nack_q, ovf_q;
  logic [DIV_W-1:0] div_q;
  logic             sda_s1, sda_s2;
  logic             ctrl_wr, push_wr, drop_wr;
  logic             q_in_ready, q_out_valid, q_out_ready, q_clr;
  cmd_word_t        q_out_data;
  logic             tick, restart, busy, nack_evt;
  logic [15:0]      status;

  assign ctrl_wr = reg_wr && (reg_addr == RA_CTRL);
  assign push_wr = reg_wr && (reg_addr == RA_PUSH) && !hold_q;
  assign drop_wr = push_wr && !q_in_ready;
  assign q_clr   = hold_q || nack_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      hold_q <= 1'b0;
      nack_q <= 1'b0;
      ovf_q  <= 1'b0;
      div_q  <= DIV_RST;
      sda_s1 <= 1'b1;
      sda_s2 <= 1'b1;
    end else begin
      sda_s1 <= sda_in;
      sda_s2 <= sda_s1;
      if (ctrl_wr) begin
        en_q   <= reg_wdata[0];
        hold_q <= reg_wdata[1];
      end
      if (reg_wr && reg_addr == RA_DIV) div_q <= reg_wdata[DIV_W-1:0];
      if (nack_evt)     nack_q <= 1'b1;
      else if (ctrl_wr) nack_q <= 1'b0;
      if (drop_wr)      ovf_q <= 1'b1;
      else if (ctrl_wr) ovf_q <= 1'b0;
    end
  end

  i2cm_cmd_fifo #(.DEPTH(DEPTH)) u_queue (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (q_clr),
    .in_valid  (push_wr),
    .in_ready  (q_in_ready),
    .in_data   (cmd_word_t'(reg_wdata[CMD_W-1:0])),
    .out_valid (q_out_valid),
    .out_ready (q_out_ready),
    .out_data  (q_out_data)
  );

  i2cm_qtick #(.DIV_W(DIV_W)) u_qtick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (restart),
    .div     (div_q),
    .tick    (tick)
  );

  i2cm_engine u_engine (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (en_q),
    .cmd_valid (q_out_valid),
    .cmd_ready (q_out_ready),
    .cmd_data  (q_out_data),
    .tick      (tick),
    .restart   (restart),
    .sda_in    (sda_s2),
    .scl_oe    (scl_oe),
    .sda_oe    (sda_oe),
    .busy      (busy),
    .nack_evt  (nack_evt)
  );

  assign status = {8'h00, !q_out_valid, 1'b1, !q_in_ready, 2'b00, busy, nack_q, ovf_q};

  always_comb begin
    case (reg_addr)
      RA_CTRL:   reg_rdata = {14'h0, hold_q, en_q};
      RA_STATUS: reg_rdata = status;
      RA_DIV:    reg_rdata = 16'(div_q);
      default:   reg_rdata = 16'h0;
    endcase
  end

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    drop_wr |=> ovf_q); // R9

  AST_NACK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (nack_q && !ctrl_wr) |=> nack_q); // R5

  AST_HOLD_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |-> !q_out_valid || $rose(hold_q)); // R10

endmodule

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb;

  localparam int DEPTH = 8;
  localparam int DEFDIV = 4;
  localparam logic [11:0] EV_START = 12'h800;
  localparam logic [11:0] EV_STOP  = 12'h400;
  // vector: {addr byte, byte 1, byte 2, nack position (3 = none)}
  localparam logic [31:0] VEC [6] = '{
    32'h34_00_89_03, 32'h34_5A_C3_03, 32'h34_11_22_00,
    32'h34_80_01_01, 32'h34_FF_7E_02, 32'hA6_01_02_03 };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd1;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        scl_oe, sda_oe, sda_in;
  logic        scl_w, sda_w;
  logic        slv_pull = 1'b0;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assign scl_w  = ~scl_oe;
  assign sda_w  = ~(sda_oe | slv_pull);
  assign sda_in = sda_w;

  i2c_cmd_master #(.DEPTH(DEPTH), .DIV_W(16), .DEFAULT_DIV(DEFDIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sda_in(sda_in),
    .scl_oe(scl_oe), .sda_oe(sda_oe));

  // target model and event log
  logic [11:0] ev [256];
  int   ev_n = 0, byte_cnt = 0, bc_base = 0, nack_at = 3;
  int   bitcnt = 0, t_rise = 0, last_high = 0;
  logic ack_phase = 1'b0, prev_scl = 1'b1, prev_sda = 1'b1, ack;
  logic [7:0] shreg = 8'h0;

  always @(scl_w, sda_w) begin
    if (scl_w === 1'b1 && prev_scl === 1'b0) begin
      t_rise = cyc;
      if (ack_phase) bitcnt = 0;
      else if (bitcnt < 8) begin shreg = {shreg[6:0], sda_w}; bitcnt++; end
    end else if (scl_w === 1'b0 && prev_scl === 1'b1) begin
      last_high = cyc - t_rise;
      if (ack_phase) begin slv_pull = 1'b0; ack_phase = 1'b0; end
      else if (bitcnt == 8) begin
        ack_phase = 1'b1;
        ack = ((byte_cnt - bc_base) != nack_at);
        slv_pull = ack;
        ev[ev_n % 256] = {3'b000, !ack, shreg};
        ev_n++;
        byte_cnt++;
      end
    end else if (scl_w === 1'b1 && prev_scl === 1'b1) begin
      if (sda_w === 1'b0 && prev_sda === 1'b1) begin
        ev[ev_n % 256] = EV_START; ev_n++; bitcnt = 0; ack_phase = 1'b0;
      end else if (sda_w === 1'b1 && prev_sda === 1'b0) begin
        ev[ev_n % 256] = EV_STOP; ev_n++;
      end
    end
    prev_scl = scl_w;
    prev_sda = sda_w;
  end

  logic [11:0] exp_ev [32];
  int exp_n = 0;
  int ev_base = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd1;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
    reg_addr = 2'd1;
  endtask

  task automatic wait_idle(input string tag);
    logic [15:0] s;
    for (int k = 0; k < 20000; k++) begin
      rd(2'd1, s);
      if (s[7] && !s[2]) return;
    end
    check({tag, " idle timeout"}, 0, 1);
  endtask

  task automatic begin_xfer(input int nack_pos);
    nack_at = nack_pos; bc_base = byte_cnt; ev_base = ev_n; exp_n = 0;
  endtask

  task automatic push_exp(input logic [11:0] e);
    exp_ev[exp_n] = e; exp_n++;
  endtask

  task automatic cmp_events(input string tag);
    check({tag, " event count"}, ev_n - ev_base, exp_n);
    for (int k = 0; k < exp_n; k++)
      check({tag, " event"}, ev[(ev_base + k) % 256], exp_ev[k]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [15:0] s;
    logic [7:0]  b [3];
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    ev_n = 0;

    // R1 reset state
    rd(2'd1, s);
    check("R1 status after reset", s, 16'h00C0);
    check("R1 lines released", {scl_w, sda_w}, 2'b11);

    wr(2'd0, 16'h1);

    // table: R2 R3 R4 R6 with ACKs, R5 with NACK at each position, R11 default
    for (int i = 0; i < 6; i++) begin
      int np;
      b[0] = VEC[i][31:24]; b[1] = VEC[i][23:16]; b[2] = VEC[i][15:8];
      np = int'(VEC[i][7:0]);
      begin_xfer(np);
      push_exp(EV_START);
      for (int k = 0; k < 3; k++) begin
        if (k <= np) push_exp({3'b000, (k == np), b[k]});
      end
      push_exp(EV_STOP);
      wr(2'd2, {6'h0, 2'b01, b[0]});
      wr(2'd2, {6'h0, 2'b00, b[1]});
      wr(2'd2, {6'h0, 2'b10, b[2]});
      wait_idle("R6 table");
      cmp_events("R3 R4 R6 table transfer");
      if (i == 0) check("R11 SCL high time default", last_high, 2 * (DEFDIV + 1));
      if (np < 3) begin
        rd(2'd1, s);
        check("R5 NACK sticky and queue empty", {s[7], s[1]}, 2'b11);
        repeat (400) @(posedge clk);
        check("R5 no activity after NACK", ev_n - ev_base, exp_n);
        wr(2'd0, 16'h1);
        rd(2'd1, s);
        check("R5 control write clears NACK", s, 16'h00C0);
      end else begin
        rd(2'd1, s);
        check("R6 idle after STOP", s, 16'h00C0);
      end
    end

    // R7 repeated start
    begin_xfer(9);
    push_exp(EV_START); push_exp(12'h034); push_exp(12'h05A);
    push_exp(EV_START); push_exp(12'h034); push_exp(12'h0A5); push_exp(EV_STOP);
    wr(2'd2, 16'h134); wr(2'd2, 16'h05A); wr(2'd2, 16'h134); wr(2'd2, 16'h2A5);
    wait_idle("R7");
    cmp_events("R7 repeated START");

    // R2 idle word without START flag still starts
    begin_xfer(9);
    push_exp(EV_START); push_exp(12'h0C3); push_exp(EV_STOP);
    wr(2'd2, 16'h2C3);
    wait_idle("R2");
    cmp_events("R2 START from idle");

    // R8 stall with SCL low
    begin_xfer(9);
    wr(2'd2, 16'h134);
    repeat (800) @(posedge clk);
    @(negedge clk);
    check("R8 SCL held low", scl_w, 1'b0);
    rd(2'd1, s);
    check("R8 busy while stalled", s[2], 1'b1);
    check("R8 events while stalled", ev_n - ev_base, 2);
    wr(2'd2, 16'h2AA);
    wait_idle("R8");
    push_exp(EV_START); push_exp(12'h034); push_exp(12'h0AA); push_exp(EV_STOP);
    cmp_events("R8 resume");

    // R10 disabled: nothing fetched
    begin_xfer(9);
    wr(2'd0, 16'h0);
    wr(2'd2, 16'h134); wr(2'd2, 16'h2AB);
    repeat (300) @(posedge clk);
    check("R10 no bus activity when disabled", ev_n - ev_base, 0);
    rd(2'd1, s);
    check("R10 words stay queued", s[7], 1'b0);

    // R9 overflow
    for (int k = 0; k < DEPTH - 1; k++) wr(2'd2, 16'h055);
    rd(2'd1, s);
    check("R9 full and overflow", {s[5], s[0]}, 2'b11);

    // R10 queue hold, R9 clear by control write
    wr(2'd0, 16'h2);
    rd(2'd1, s);
    check("R10 hold empties queue, R9 cleared", s, 16'h00C0);
    rd(2'd0, s);
    check("R10 control readback", s, 16'h0002);
    wr(2'd2, 16'h1FF);
    wr(2'd0, 16'h1);
    repeat (300) @(posedge clk);
    check("R10 write during hold dropped", ev_n - ev_base, 0);
    rd(2'd1, s);
    check("R10 status after hold", s, 16'h00C0);

    // R11 programmed divider
    wr(2'd3, 16'h3);
    rd(2'd3, s);
    check("R11 divider readback", s, 16'h0003);
    begin_xfer(9);
    push_exp(EV_START); push_exp(12'h034); push_exp(12'h0E1); push_exp(EV_STOP);
    wr(2'd2, 16'h134); wr(2'd2, 16'h2E1);
    wait_idle("R11");
    cmp_events("R11 transfer at DIV=3");
    check("R11 SCL high time DIV=3", last_high, 8);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule